// File: doc/BRIEF.md
# Debug Bus Address/Data Match Comparator

This block sits beside a processor bus as a passive watcher. On every valid bus cycle it looks at the address, the data, the direction and the access width. When the programmed condition holds, it raises a one-cycle match pulse on the next clock. Software or a debug host sets the condition through a small register write port. The block itself never drives the bus.

In single mode, one reference address must be equal to the bus address. The access width can optionally be checked. The data bus is compared against a reference value under a per-bit mask, and the comparison can match on equality or on inequality. An all-clear mask has opposite effects in the two polarities: with equality it drops the data from the test, and with inequality it makes a match impossible.

In range mode, the two reference addresses act as inclusive lower and upper bounds. The data and direction qualifiers still apply in this mode, and the access width is not checked. Data is big-endian. The upper byte lane holds the byte at the even address n, and the lower lane holds the byte at n+1.

Top module: `bus_match_unit`

## Requirements
- R1: After reset every configuration register reads as zero, `match_o` is low, and with the enable bit (control bit 0) clear no bus cycle produces a match.
- R2: In single mode (control bit 1 clear) a match requires `bus_addr` to equal the reference address written at offset 1.
- R3: With the polarity bit (control bit 2) clear, data bits whose mask bit (offset 4) is set must equal the reference value (offset 3); bits with a clear mask bit are ignored.
- R4: With the polarity bit clear and the effective mask all zero, the data bus is ignored and the address alone decides.
- R5: With the polarity bit set, the data qualifies when at least one masked bit differs from the reference value.
- R6: With the polarity bit set and the effective mask all zero, no match occurs, even on an equal address.
- R7: In single mode with size-check (control bit 3) set, `bus_word` must equal the size bit (control bit 4: 0 = byte, 1 = word); with size-check clear the width is not checked.
- R8: A word access (`bus_word`=1) compares both lanes, with data[15:8] as the byte at n and data[7:0] as the byte at n+1. A byte access compares only the upper lane when its mask byte is nonzero, and otherwise only the lower lane.
- R9: In range mode (control bit 1 set) the address qualifies when offset-1 value <= `bus_addr` <= offset-2 value, both bounds included.
- R10: In range mode the size bits are ignored, while the data mask and the direction qualifier still apply.
- R11: With direction-check (control bit 5) set, `bus_rd` must equal the direction bit (control bit 6, 1 = read); with it clear the direction is not checked.
- R12: `match_o` is registered. It is high for exactly the cycle after a qualifying cycle with `bus_valid` high, and it never rises after a cycle with `bus_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register offset: 0 control, 1 address A, 2 address B, 3 data value, 4 data mask |
| cfg_wdata | input | CFG_W (16) | Register write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_data | input | 2*BYTE_W (16) | Bus data, upper lane = byte at even address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match_o | output | 1 | Registered match pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address and 8-bit byte lanes, giving a 16-bit data bus. At this size, every lane-selection pattern can be written directly, with each lane fully masked, partly masked or empty. The range bounds can also be placed so that the cycles just below, exactly on and just above each bound are all reached in a few bus cycles. Each scenario reprograms the registers and then checks both polarities and both access widths against hand-derived outcomes.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_ADDRA = 3'd1;
  localparam logic [REG_AW-1:0] OFF_ADDRB = 3'd2;
  localparam logic [REG_AW-1:0] OFF_DVAL  = 3'd3;
  localparam logic [REG_AW-1:0] OFF_DMASK = 3'd4;

  // control fields, bit 0 is the enable
  typedef struct packed {
    logic dir;     // bit 6: 1 = read
    logic dir_en;  // bit 5
    logic sz;      // bit 4: 1 = word
    logic sz_en;   // bit 3
    logic inv;     // bit 2: match on inequality
    logic range;   // bit 1
    logic en;      // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_GE = 2'd1,
    CMP_LE = 2'd2
  } cmp_kind_e;
endpackage

// File: rtl/bmu_cfg_regs.sv
module bmu_cfg_regs
  import bmu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [REG_AW-1:0]   waddr,
  input  logic [CFG_W-1:0]    wdata,
  output ctrl_t               ctrl,
  output logic [ADDR_W-1:0]   addr_a,
  output logic [ADDR_W-1:0]   addr_b,
  output logic [DATA_W-1:0]   dval,
  output logic [DATA_W-1:0]   dmask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      addr_a <= '0;
      addr_b <= '0;
      dval   <= '0;
      dmask  <= '0;
    end else if (we) begin
      case (waddr)
        OFF_CTRL:  ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
        OFF_ADDRA: addr_a <= wdata[ADDR_W-1:0];
        OFF_ADDRB: addr_b <= wdata[ADDR_W-1:0];
        OFF_DVAL:  dval   <= wdata[DATA_W-1:0];
        OFF_DMASK: dmask  <= wdata[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  // R1
  cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl == '0 && addr_a == '0 && addr_b == '0 && dval == '0 && dmask == '0));
endmodule

// File: rtl/bmu_addr_cmp.sv
module bmu_addr_cmp
  import bmu_pkg::*;
#(
  parameter int        ADDR_W = 16,
  parameter cmp_kind_e KIND   = CMP_EQ
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              hit
);
  generate
    if (KIND == CMP_EQ) begin : g_eq
      assign hit = (bus_addr == ref_addr);
    end else if (KIND == CMP_GE) begin : g_ge
      assign hit = (bus_addr >= ref_addr);
    end else begin : g_le
      assign hit = (bus_addr <= ref_addr);
    end
  endgenerate
endmodule

// File: rtl/bmu_data_cmp.sv
module bmu_data_cmp #(
  parameter int BYTE_W = 8,
  localparam int LANES = 2,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv,
  input  logic              word,
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] bus_data,
  output logic              data_ok
);
  // lane 0 = upper byte (address n), lane 1 = lower byte (address n+1)
  logic              hi_used;
  logic [LANES-1:0]  lane_on;
  logic [DATA_W-1:0] emask;
  logic [DATA_W-1:0] diff;

  assign hi_used    = |mask[DATA_W-1 -: BYTE_W];
  assign lane_on[0] = word | hi_used;
  assign lane_on[1] = word | ~hi_used;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int TOP = DATA_W - 1 - l * BYTE_W;
      assign emask[TOP -: BYTE_W] = mask[TOP -: BYTE_W] & {BYTE_W{lane_on[l]}};
    end
  endgenerate

  assign diff    = (bus_data ^ val) & emask;
  assign data_ok = inv ? (|diff) : ~(|diff);

  // R4
  eq_open_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!inv && mask == '0) |-> data_ok);
  // R6
  inv_closed_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (inv && mask == '0) |-> !data_ok);
  // R8
  byte_hi_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (!word && !inv && hi_used &&
     ((bus_data[DATA_W-1 -: BYTE_W] ^ val[DATA_W-1 -: BYTE_W]) & mask[DATA_W-1 -: BYTE_W]) == '0)
    |-> data_ok);
endmodule

// File: rtl/bus_match_unit.sv
module bus_match_unit
  import bmu_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int CFG_W  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              bus_word,
  output logic              match_o
);
  localparam int NCMP = 3;

  ctrl_t             ctrl;
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic [DATA_W-1:0] dval, dmask;
  logic [NCMP-1:0]   hit;
  logic              data_ok, addr_ok, size_ok, dir_ok, cond, match_q;

  bmu_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .addr_a(addr_a), .addr_b(addr_b), .dval(dval), .dmask(dmask)
  );

  // hit[0]: equal to A, hit[1]: at or above A, hit[2]: at or below B
  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      localparam cmp_kind_e K = (i == 0) ? CMP_EQ : ((i == 1) ? CMP_GE : CMP_LE);
      bmu_addr_cmp #(.ADDR_W(ADDR_W), .KIND(K)) u_cmp (
        .bus_addr(bus_addr),
        .ref_addr((i == 2) ? addr_b : addr_a),
        .hit(hit[i])
      );
    end
  endgenerate

  bmu_data_cmp #(.BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rst(rst), .inv(ctrl.inv), .word(bus_word),
    .val(dval), .mask(dmask), .bus_data(bus_data), .data_ok(data_ok)
  );

  assign addr_ok = ctrl.range ? (hit[1] & hit[2]) : hit[0];
  assign size_ok = ctrl.range | ~ctrl.sz_en | (bus_word == ctrl.sz);
  assign dir_ok  = ~ctrl.dir_en | (bus_rd == ctrl.dir);
  assign cond    = bus_valid & ctrl.en & addr_ok & size_ok & dir_ok & data_ok;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= cond;
  end

  assign match_o = match_q;

  // R12
  valid_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !match_o);
  // R1
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> !match_o);
  // R9
  range_bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.range && bus_valid && ctrl.en) ##1 match_o |->
      ($past(bus_addr) >= $past(addr_a) && $past(bus_addr) <= $past(addr_b)));
  // R2
  single_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.range && bus_addr != addr_a) |=> !match_o);
  // R11
  dir_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dir_en && bus_rd != ctrl.dir) |=> !match_o);
  // R7
  size_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.range && ctrl.sz_en && bus_word != ctrl.sz) |=> !match_o);
endmodule

// File: tb/bus_match_unit_bench.sv
module bus_match_unit_bench;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int C_EN = 1, C_RANGE = 2, C_INV = 4, C_SZEN = 8, C_SZ = 16, C_DIREN = 32, C_DIR = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic          bus_rd = 1'b0;
  logic          bus_word = 1'b0;
  logic          match_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  typedef struct {
    int    due;
    bit    exp;
    string tag;
  } item_t;
  item_t sb[$];

  bus_match_unit u_bus_match_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_word(bus_word), .match_o(match_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops results due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if (match_o !== it.exp) begin
        mismatched++;
        $display("FAIL %s: match_o=%b expected=%b (cycle %0d)", it.tag, match_o, it.exp, cyc);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ctrl, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] v, input logic [15:0] m);
    wr(3'd1, a); wr(3'd2, b); wr(3'd3, v); wr(3'd4, m); wr(3'd0, 16'(ctrl));
  endtask

  // driver: one bus cycle, expectation due after the next rising edge
  task automatic cyc_bus(input logic vld, input logic [15:0] a, input logic [15:0] d,
                         input logic rd, input logic wd, input bit exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_valid = vld; bus_addr = a; bus_data = d; bus_rd = rd; bus_word = wd;
    it.due = cyc + 1; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compared++;
    if (match_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: match_o=%b expected=0 after reset", match_o);
    end
    // R1: zero configuration never matches
    cyc_bus(1, 16'h0000, 16'h0000, 0, 1, 0, "R1 zero config");
    cyc_bus(1, 16'h0000, 16'h0000, 1, 0, 0, "R1 zero config read");

    // R4 / R2: equality, empty mask
    setup(C_EN, 16'h1234, 16'h0000, 16'hABCD, 16'h0000);
    cyc_bus(1, 16'h1234, 16'h5555, 0, 1, 1, "R4 address only");
    cyc_bus(1, 16'h1236, 16'hABCD, 0, 1, 0, "R2 address differs");
    cyc_bus(0, 16'h1234, 16'hABCD, 0, 1, 0, "R12 valid low");
    cyc_bus(1, 16'h1234, 16'h0000, 1, 0, 1, "R12 back to back 1");
    cyc_bus(1, 16'h1234, 16'h0000, 1, 0, 1, "R12 back to back 2");

    // R3: equality under masks
    setup(C_EN, 16'h1234, 16'h0000, 16'hABCD, 16'hFFFF);
    cyc_bus(1, 16'h1234, 16'hABCD, 0, 1, 1, "R3 full equal");
    cyc_bus(1, 16'h1234, 16'hABCC, 0, 1, 0, "R3 one bit off");
    wr(3'd4, 16'h0F0F);
    cyc_bus(1, 16'h1234, 16'h5B6D, 0, 1, 1, "R3 masked bits ignored");
    cyc_bus(1, 16'h1234, 16'h5B6C, 0, 1, 0, "R3 masked bit differs");

    // R5 / R6: inequality
    setup(C_EN | C_INV, 16'h1234, 16'h0000, 16'hABCD, 16'hFFFF);
    cyc_bus(1, 16'h1234, 16'hABCD, 0, 1, 0, "R5 equal data no match");
    cyc_bus(1, 16'h1234, 16'hABCF, 0, 1, 1, "R5 differing data");
    cyc_bus(1, 16'h1236, 16'h0000, 0, 1, 0, "R2 inverse wrong address");
    wr(3'd4, 16'h0000);
    cyc_bus(1, 16'h1234, 16'hABCF, 0, 1, 0, "R6 empty mask inverse");
    cyc_bus(1, 16'h1234, 16'h0000, 1, 0, 0, "R6 empty mask inverse byte");

    // R7: size qualification
    setup(C_EN | C_SZEN, 16'h2000, 16'h0000, 16'h0000, 16'h0000);
    cyc_bus(1, 16'h2000, 16'h0000, 0, 0, 1, "R7 byte wanted byte");
    cyc_bus(1, 16'h2000, 16'h0000, 0, 1, 0, "R7 byte wanted word");
    wr(3'd0, 16'(C_EN | C_SZEN | C_SZ));
    cyc_bus(1, 16'h2000, 16'h0000, 0, 1, 1, "R7 word wanted word");
    cyc_bus(1, 16'h2000, 16'h0000, 0, 0, 0, "R7 word wanted byte");
    wr(3'd0, 16'(C_EN | C_SZ));
    cyc_bus(1, 16'h2000, 16'h0000, 0, 0, 1, "R7 size check off");

    // R8: byte lanes
    setup(C_EN, 16'h3000, 16'h0000, 16'hABCD, 16'hFF00);
    cyc_bus(1, 16'h3000, 16'hAB00, 0, 0, 1, "R8 byte upper lane");
    cyc_bus(1, 16'h3000, 16'h12CD, 0, 0, 0, "R8 byte upper lane differs");
    wr(3'd4, 16'h00FF);
    cyc_bus(1, 16'h3000, 16'h99CD, 0, 0, 1, "R8 byte lower lane");
    cyc_bus(1, 16'h3000, 16'hCDAB, 0, 0, 0, "R8 byte lower lane differs");
    cyc_bus(1, 16'h3000, 16'h99CD, 0, 1, 1, "R8 word lower lane");
    wr(3'd4, 16'hFFFF);
    cyc_bus(1, 16'h3000, 16'hAB00, 0, 0, 1, "R8 byte ignores lower lane");
    cyc_bus(1, 16'h3000, 16'hAB00, 0, 1, 0, "R8 word compares both lanes");

    // R11: direction
    setup(C_EN | C_DIREN | C_DIR, 16'h4000, 16'h0000, 16'h0000, 16'h0000);
    cyc_bus(1, 16'h4000, 16'h0000, 1, 1, 1, "R11 read wanted read");
    cyc_bus(1, 16'h4000, 16'h0000, 0, 1, 0, "R11 write wanted read");
    wr(3'd0, 16'(C_EN | C_DIREN));
    cyc_bus(1, 16'h4000, 16'h0000, 0, 1, 1, "R11 write wanted write");
    cyc_bus(1, 16'h4000, 16'h0000, 1, 1, 0, "R11 read wanted write");
    wr(3'd0, 16'(C_EN | C_DIR));
    cyc_bus(1, 16'h4000, 16'h0000, 0, 1, 1, "R11 direction check off");

    // R9: inclusive range
    setup(C_EN | C_RANGE, 16'h1000, 16'h10FF, 16'h0000, 16'h0000);
    cyc_bus(1, 16'h0FFF, 16'h0000, 0, 1, 0, "R9 below lower");
    cyc_bus(1, 16'h1000, 16'h0000, 0, 1, 1, "R9 at lower");
    cyc_bus(1, 16'h1080, 16'h0000, 0, 1, 1, "R9 inside");
    cyc_bus(1, 16'h10FF, 16'h0000, 0, 1, 1, "R9 at upper");
    cyc_bus(1, 16'h1100, 16'h0000, 0, 1, 0, "R9 above upper");

    // R10: size ignored, data and direction apply in range mode
    wr(3'd0, 16'(C_EN | C_RANGE | C_SZEN | C_SZ));
    cyc_bus(1, 16'h1080, 16'h0000, 0, 0, 1, "R10 size ignored byte");
    cyc_bus(1, 16'h1080, 16'h0000, 0, 1, 1, "R10 size ignored word");
    wr(3'd3, 16'hAB00); wr(3'd4, 16'hFF00);
    cyc_bus(1, 16'h1080, 16'hAB11, 0, 1, 1, "R10 data qualifies");
    cyc_bus(1, 16'h1080, 16'hAC11, 0, 1, 0, "R10 data rejects");
    cyc_bus(1, 16'h1180, 16'hAB11, 0, 1, 0, "R10 outside range");
    wr(3'd0, 16'(C_EN | C_RANGE | C_DIREN | C_DIR));
    cyc_bus(1, 16'h1080, 16'hAB11, 0, 1, 0, "R10 direction rejects");
    cyc_bus(1, 16'h1080, 16'hAB11, 1, 1, 1, "R10 direction qualifies");

    // R1: disabled again
    wr(3'd0, 16'(C_RANGE));
    cyc_bus(1, 16'h1080, 16'hAB11, 1, 1, 0, "R1 disabled");
    cyc_bus(0, 16'h0000, 16'h0000, 0, 0, 0, "R12 idle");

    repeat (4) @(negedge clk);
    compared++;
    if (sb.size() != 0) begin
      mismatched++;
      $display("FAIL R12: %0d results pending, expected 0", sb.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule